// File: doc/BRIEF.md
# Audio Serial Converter Interrupt Controller

This block collects every interrupt condition of a converter that places an I2S framing layer in front of a synchronous serial port. It detects three error conditions of its own: a serial port configured for the wrong data length, a wrong word length seen from an external codec in slave mode, and a transmit start with an empty transmit FIFO. It merges these with four interrupt lines from the serial port and drives a single interrupt output, which takes the place of the serial port's own combined line.

The raw state of all seven sources and the masked state of all seven sources are always visible on the ports. The three converter errors are sticky and are cleared by writing ones. Only these three have a writable enable. The four serial-port sources follow their input lines, and their enable positions read back the live status.

The block also overrides the transmit path when the FIFO underruns. If the converter is enabled, the datum entering the transmit delay pipe is forced to zero and the frame pulse toward the serial port is withheld. If the converter is disabled, both pass through untouched.

Top module: `audio_irq_ctrl`

## Requirements
- R1: The four serial-port lines appear level-for-level, in the same cycle, at bit positions 3 (receive service), 4 (transmit service), 5 (receive overrun) and 6 (receive timeout) of both the raw and the masked status.
- R2: Raw status bit 0 is set one clock after a cycle in which the port enable and the converter enable are both high and `cfg_len` differs from the parameter `FRAME_LEN` (default 16). It is never set by a matching length or while either enable is low.
- R3: Raw status bit 1 is set when the converter is enabled in slave mode and the number of bit-clock ticks between two successive word-select edges differs from `FRAME_LEN`. The first edge after entering slave mode is not checked, and master mode never sets the bit.
- R4: Raw status bit 2 is set one clock after a cycle with a transmit start while the transmit FIFO is empty, whether or not the converter is enabled.
- R5: Raw bits 0 to 2 hold until a 1 is written at the same position with `reg_clr_we`. When a new error and its clear arrive in the same cycle, the bit stays set.
- R6: Only enable bits 0 to 2 are writable through `reg_mask_we`. Enable bits 3 to 6 read back as raw status bits 3 to 6, and writes to them have no effect.
- R7: Masked bits 0 to 2 equal raw AND enable. Masked bits 3 to 6 equal raw.
- R8: `irq_out` is high exactly when any masked status bit is high.
- R9: In a cycle with an underrun start while the converter is enabled, `pipe_din_out` is 0 and `fpulse_out` is 0.
- R10: With the converter disabled, or with no underrun, `pipe_din_out` and `fpulse_out` equal their inputs.
- R11: After reset, raw bits 0 to 2 and enable bits 0 to 2 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enabled |
| conv_en | input | 1 | Converter enabled |
| slave_mode | input | 1 | 1: external codec drives the bit clock and word select |
| cfg_len | input | LEN_W | Data length configured in the serial port |
| bclk_tick | input | 1 | One-cycle strobe per bit clock |
| ws_in | input | 1 | Word-select level, sampled on `bclk_tick` |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_start | input | 1 | Strobe: a new transmission begins |
| sp_rx_req | input | 1 | Serial port receive service interrupt |
| sp_tx_req | input | 1 | Serial port transmit service interrupt |
| sp_rx_ovr | input | 1 | Serial port receive overrun interrupt |
| sp_rx_tmo | input | 1 | Serial port receive timeout interrupt |
| reg_mask_we | input | 1 | Write `reg_wdata` to the enable register |
| reg_clr_we | input | 1 | Clear raw error bits where `reg_wdata` is 1 |
| reg_wdata | input | 7 | Write data |
| pipe_din_in | input | 1 | Datum headed for the transmit delay pipe |
| fpulse_in | input | 1 | Frame pulse headed for the serial port |
| pipe_din_out | output | 1 | Datum after the underrun override |
| fpulse_out | output | 1 | Frame pulse after the underrun override |
| raw_stat | output | 7 | Raw status of all sources |
| mask_stat | output | 7 | Enable register readback |
| masked_stat | output | 7 | Masked status |
| irq_out | output | 1 | Combined interrupt |

## Verification
The length check is driven with word-select periods equal to `FRAME_LEN` and then one short period. This separates a correct check from one that also fires on the unarmed first edge, from one that is off by one tick, and from one that ignores the mode input, which is tested by repeating the short period in master mode. The configured-length error is tried with a wrong length under each combination of enables, which shows whether both enables are required. The underrun path is tried with the converter enabled and disabled, and with a start on a non-empty FIFO, which separates the status flag, which ignores the enable, from the override, which depends on it. Writes of all ones to the enable and clear registers show that the serial-port positions ignore writes, and a clear issued in the same cycle as a fresh error shows that the set takes priority.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    localparam int NSRC  = 7;
    localparam int NCONV = 3;

    typedef enum logic [2:0] {
        SRC_CFG_LEN  = 3'd0,
        SRC_CODEC    = 3'd1,
        SRC_UNDERRUN = 3'd2,
        SRC_SP_RX    = 3'd3,
        SRC_SP_TX    = 3'd4,
        SRC_SP_OVR   = 3'd5,
        SRC_SP_TMO   = 3'd6
    } src_idx_e;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [NCONV-1:0] conv_vec_t;

    typedef struct packed {
        logic underrun;
        logic codec_len;
        logic cfg_len;
    } conv_err_t;

    typedef struct packed {
        logic tmo;
        logic ovr;
        logic tx;
        logic rx;
    } sp_irq_t;

    function automatic src_vec_t join_status(conv_vec_t conv, sp_irq_t sp);
        return {sp, conv};
    endfunction

endpackage

// File: rtl/ws_len_monitor.sv
module ws_len_monitor #(
    parameter int FRAME_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bclk_tick,
    input  logic ws_in,
    output logic len_bad
);
    localparam int CNT_W = $clog2(FRAME_LEN) + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             ws_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             edge_seen;
    logic [CNT_W:0]   measured;

    assign edge_seen = bclk_tick && (ws_in != ws_q);
    assign measured  = {1'b0, cnt} + 1'b1;
    assign len_bad   = active && armed && edge_seen && (measured != (CNT_W+1)'(FRAME_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q  <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!active) begin
            ws_q  <= ws_in;
            armed <= 1'b0;
            cnt   <= '0;
        end else if (bclk_tick) begin
            ws_q <= ws_in;
            if (edge_seen) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: a mismatch can only be reported once an earlier edge has armed the check
    assert_armed_first_R3: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && active && !armed) |=> armed);

endmodule

// File: rtl/underrun_guard.sv
module underrun_guard (
    input  logic conv_en,
    input  logic tx_empty,
    input  logic tx_start,
    input  logic pipe_din_in,
    input  logic fpulse_in,
    output logic underrun,
    output logic pipe_din_out,
    output logic fpulse_out
);
    logic force_zero;

    assign underrun     = tx_start && tx_empty;
    assign force_zero   = underrun && conv_en;
    assign pipe_din_out = force_zero ? 1'b0 : pipe_din_in;
    assign fpulse_out   = force_zero ? 1'b0 : fpulse_in;

    // R10: a start on a non-empty FIFO never alters the path
    always_comb begin
        if (!tx_empty) assert_passthru_R10: assert (fpulse_out == fpulse_in);
    end

endmodule

// File: rtl/err_bank.sv
module err_bank
    import audio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  conv_vec_t set_in,
    input  conv_vec_t clr_in,
    input  logic      mask_we,
    input  conv_vec_t mask_wdata,
    output conv_vec_t raw_q,
    output conv_vec_t mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_in) | set_in;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (|(clr_in & ~set_in)) |=> ((raw_q & $past(clr_in & ~set_in)) == '0));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(raw_q) & ~$past(clr_in) & ~raw_q) == '0));

endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
    import audio_irq_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int LEN_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             conv_en,
    input  logic             slave_mode,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             bclk_tick,
    input  logic             ws_in,
    input  logic             tx_empty,
    input  logic             tx_start,
    input  logic             sp_rx_req,
    input  logic             sp_tx_req,
    input  logic             sp_rx_ovr,
    input  logic             sp_rx_tmo,
    input  logic             reg_mask_we,
    input  logic             reg_clr_we,
    input  logic [NSRC-1:0]  reg_wdata,
    input  logic             pipe_din_in,
    input  logic             fpulse_in,
    output logic             pipe_din_out,
    output logic             fpulse_out,
    output logic [NSRC-1:0]  raw_stat,
    output logic [NSRC-1:0]  mask_stat,
    output logic [NSRC-1:0]  masked_stat,
    output logic             irq_out
);
    conv_err_t err_set;
    conv_vec_t err_clr;
    conv_vec_t err_raw;
    conv_vec_t err_mask;
    sp_irq_t   sp_lines;
    logic      codec_bad;
    logic      underrun;

    ws_len_monitor #(.FRAME_LEN(FRAME_LEN)) u_wsmon (
        .clk       (clk),
        .rst       (rst),
        .active    (conv_en && slave_mode),
        .bclk_tick (bclk_tick),
        .ws_in     (ws_in),
        .len_bad   (codec_bad)
    );

    underrun_guard u_guard (
        .conv_en      (conv_en),
        .tx_empty     (tx_empty),
        .tx_start     (tx_start),
        .pipe_din_in  (pipe_din_in),
        .fpulse_in    (fpulse_in),
        .underrun     (underrun),
        .pipe_din_out (pipe_din_out),
        .fpulse_out   (fpulse_out)
    );

    always_comb begin
        err_set.cfg_len   = port_en && conv_en && (cfg_len != LEN_W'(FRAME_LEN));
        err_set.codec_len = codec_bad;
        err_set.underrun  = underrun;
        err_clr           = reg_clr_we ? reg_wdata[NCONV-1:0] : '0;
        sp_lines          = '{tmo: sp_rx_tmo, ovr: sp_rx_ovr, tx: sp_tx_req, rx: sp_rx_req};
    end

    err_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .set_in     (err_set),
        .clr_in     (err_clr),
        .mask_we    (reg_mask_we),
        .mask_wdata (reg_wdata[NCONV-1:0]),
        .raw_q      (err_raw),
        .mask_q     (err_mask)
    );

    always_comb begin
        raw_stat    = join_status(err_raw, sp_lines);
        mask_stat   = join_status(err_mask, sp_lines);
        masked_stat = join_status(err_raw & err_mask, sp_lines);
        irq_out     = |masked_stat;
    end

    assert_cfg_len_R2: assert property (@(posedge clk) disable iff (rst)
        (port_en && conv_en && (cfg_len != LEN_W'(FRAME_LEN))) |=> raw_stat[SRC_CFG_LEN]);

    assert_underrun_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_start && tx_empty) |=> raw_stat[SRC_UNDERRUN]);

    assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (|(raw_stat & mask_stat)) |-> irq_out);

endmodule

// File: tb/sim_audio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_audio_irq_ctrl;
    localparam int FL = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_en = 0, conv_en = 0, slave_mode = 0;
    logic [4:0] cfg_len = 5'd16;
    logic bclk_tick = 0, ws_in = 0;
    logic tx_empty = 0, tx_start = 0;
    logic sp_rx_req = 0, sp_tx_req = 0, sp_rx_ovr = 0, sp_rx_tmo = 0;
    logic reg_mask_we = 0, reg_clr_we = 0;
    logic [6:0] reg_wdata = '0;
    logic pipe_din_in = 0, fpulse_in = 0;
    logic pipe_din_out, fpulse_out, irq_out;
    logic [6:0] raw_stat, mask_stat, masked_stat;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    audio_irq_ctrl #(.FRAME_LEN(FL), .LEN_W(5)) u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .conv_en(conv_en),
        .slave_mode(slave_mode), .cfg_len(cfg_len), .bclk_tick(bclk_tick),
        .ws_in(ws_in), .tx_empty(tx_empty), .tx_start(tx_start),
        .sp_rx_req(sp_rx_req), .sp_tx_req(sp_tx_req), .sp_rx_ovr(sp_rx_ovr),
        .sp_rx_tmo(sp_rx_tmo), .reg_mask_we(reg_mask_we), .reg_clr_we(reg_clr_we),
        .reg_wdata(reg_wdata), .pipe_din_in(pipe_din_in), .fpulse_in(fpulse_in),
        .pipe_din_out(pipe_din_out), .fpulse_out(fpulse_out), .raw_stat(raw_stat),
        .mask_stat(mask_stat), .masked_stat(masked_stat), .irq_out(irq_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        reg_clr_we = 1; reg_wdata = 7'h7F;
        step();
        reg_clr_we = 0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R11 raw", raw_stat, 7'h00);
        chk("R11 mask", mask_stat, 7'h00);
        chk("R11 irq", irq_out, 0);
    endtask

    task automatic t_sp_mirror();
        sp_rx_req = 1; sp_rx_ovr = 1; #1;
        chk("R1 raw", raw_stat, 7'h28);
        chk("R1 masked", masked_stat, 7'h28);
        chk("R8 irq sp", irq_out, 1);
        sp_rx_req = 0; sp_rx_ovr = 0; sp_tx_req = 1; sp_rx_tmo = 1; #1;
        chk("R1 raw2", raw_stat, 7'h50);
        sp_tx_req = 0; sp_rx_tmo = 0; #1;
        chk("R8 irq idle", irq_out, 0);
    endtask

    task automatic t_cfg_len();
        cfg_len = 5'd15; port_en = 1; conv_en = 0; step(); step();
        chk("R2 conv off", raw_stat[0], 0);
        port_en = 0; conv_en = 1; step(); step();
        chk("R2 port off", raw_stat[0], 0);
        port_en = 1; cfg_len = 5'd16; step(); step();
        chk("R2 len ok", raw_stat[0], 0);
        cfg_len = 5'd8; step();
        chk("R2 set", raw_stat[0], 1);
        cfg_len = 5'd16; port_en = 0; conv_en = 0; step();
        chk("R5 held", raw_stat[0], 1);
        clear_all();
        chk("R5 cleared", raw_stat[0], 0);
    endtask

    task automatic ws_frames(int len, int n);
        for (int i = 0; i < n; i++) begin
            ws_in = ~ws_in;
            repeat (len) step();
        end
    endtask

    task automatic t_codec();
        bclk_tick = 1; conv_en = 1; slave_mode = 1;
        ws_frames(FL, 4);
        chk("R3 good frames", raw_stat[1], 0);
        ws_frames(12, 1);
        ws_frames(FL, 1);
        chk("R3 short frame", raw_stat[1], 1);
        ws_frames(FL, 1);
        clear_all();
        chk("R5 codec clr", raw_stat[1], 0);
        ws_frames(FL + 1, 1);
        ws_frames(FL, 1);
        chk("R3 long frame", raw_stat[1], 1);
        clear_all();
        slave_mode = 0; step();
        ws_frames(FL, 2); ws_frames(12, 1); ws_frames(FL, 2);
        chk("R3 master ignored", raw_stat[1], 0);
        slave_mode = 1;
        ws_frames(5, 1);
        ws_frames(FL, 1);
        chk("R3 first edge unchecked", raw_stat[1], 1);
        bclk_tick = 0; conv_en = 0; slave_mode = 0;
        step();
        clear_all();
        chk("R3 cleared", raw_stat[1], 0);
    endtask

    task automatic t_underrun();
        pipe_din_in = 1; fpulse_in = 1;
        tx_empty = 1; tx_start = 1; conv_en = 1; #1;
        chk("R9 data", pipe_din_out, 0);
        chk("R9 pulse", fpulse_out, 0);
        step();
        tx_start = 0;
        chk("R4 set enabled", raw_stat[2], 1);
        clear_all();
        conv_en = 0; tx_start = 1; #1;
        chk("R10 data off", pipe_din_out, 1);
        chk("R10 pulse off", fpulse_out, 1);
        step();
        tx_start = 0;
        chk("R4 set disabled", raw_stat[2], 1);
        clear_all();
        conv_en = 1; tx_empty = 0; tx_start = 1; #1;
        chk("R10 not empty", {pipe_din_out, fpulse_out}, 2'b11);
        step();
        tx_start = 0;
        chk("R4 not empty", raw_stat[2], 0);
        tx_empty = 1; tx_start = 1;
        reg_clr_we = 1; reg_wdata = 7'h04;
        step();
        reg_clr_we = 0; reg_wdata = '0; tx_start = 0;
        chk("R5 set wins", raw_stat[2], 1);
        tx_empty = 0; conv_en = 0;
        clear_all();
        chk("R5 underrun clr", raw_stat[2], 0);
    endtask

    task automatic t_mask();
        reg_mask_we = 1; reg_wdata = 7'h7F;
        step();
        reg_mask_we = 0; reg_wdata = '0;
        chk("R6 writable only", mask_stat, 7'h07);
        sp_rx_ovr = 1; #1;
        chk("R6 ro mirrors", mask_stat, 7'h27);
        sp_rx_ovr = 0;
        tx_empty = 1; tx_start = 1; step();
        tx_start = 0; tx_empty = 0;
        chk("R7 masked on", masked_stat, 7'h04);
        chk("R8 irq on", irq_out, 1);
        reg_mask_we = 1; reg_wdata = 7'h03;
        step();
        reg_mask_we = 0; reg_wdata = '0;
        chk("R7 masked off", masked_stat, 7'h00);
        chk("R7 raw kept", raw_stat, 7'h04);
        chk("R8 irq off", irq_out, 0);
        clear_all();
    endtask

    logic done = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) step();
        rst = 0;
        step();
        t_reset();
        t_sp_mirror();
        t_cfg_len();
        t_codec();
        t_underrun();
        t_mask();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule